// File: doc/BRIEF.md
# Multi-mode timer with shared match register

This block is a general-purpose timer made of two 16-bit halves, A and B. The halves run on their own, or they are joined into one 32-bit timer that takes its counter, controls and flags from half A. Each half holds an interval-load value and a match value. It runs in one of four modes:

- one-shot countdown
- periodic countdown
- counting rising edges of an external input
- pulse-width modulation

Software sets it up through a flat register port. The port has a write strobe, an address and write data, and gives back combinational read data.

The match value has a different job in each mode. In the two countdown modes it is a compare point that raises a sticky interrupt flag. In edge-count mode it is the count at which counting stops. In PWM mode it is the duty threshold. When the halves are joined, half B's match storage supplies the upper 16 bits of half A's 32-bit match value. The same holds for the load value. Half B's own match and load registers then become read-only.

Register map (word addresses):

| Address | Register | Contents |
|---|---|---|
| 0 | CFG | bit0 join, bits 2:1 mode A, bits 4:3 mode B |
| 1 | CTL | bit0 enable A, bit1 enable B |
| 2 | LOAD_A | load value of half A |
| 3 | LOAD_B | load value of half B |
| 4 | MATCH_A | match value of half A |
| 5 | MATCH_B | match value of half B |
| 6 | VALUE_A | count of half A, read-only |
| 7 | VALUE_B | count of half B, read-only |
| 8 | STATUS | bit0 match A, bit1 match B, bit2 done A, bit3 done B, bit4 configuration error |
| 9 | CLEAR | write 1 to clear STATUS bits 3:0 |

Mode codes: 0 one-shot, 1 periodic, 2 edge-count, 3 PWM.

Writing 1 to an enable bit that is 0 starts that half and loads its count from its load value.

Top module: `mm_timer`

## Requirements
- R1: After reset, MATCH_A reads 0x0000FFFF, MATCH_B reads 0x0000FFFF, CTL reads 0 and STATUS reads 0. All output pins are low.
- R2: In one-shot mode (code 0) the count decrements by one per clock from the load value. The match flag sets while the count equals the match value. At zero the count holds, the enable bit clears and the done flag sets (STATUS bit2 for half A).
- R3: In periodic mode (code 1) the count holds zero for one cycle. On the next cycle it reloads from the load value, and it keeps running.
- R4: In edge-count mode (code 2) the count starts at the load value and drops by one per rising edge of the synchronized input. After load minus match edges it equals the match value. Then the done flag sets (STATUS bit3 for half B), the enable bit clears, and later edges are ignored.
- R5: In PWM mode (code 3) the pin is high for load−match+1 cycles and low for match cycles, so the period is load+1 cycles. A match of 0 keeps the pin high. When the half is disabled the pin is low.
- R6: With join set, a write to MATCH_A sets the low half and half B's match storage as one 32-bit value, and MATCH_A reads back all 32 bits. Writes to MATCH_B are ignored, and MATCH_B reads the current upper half.
- R7: Without join, MATCH_A and MATCH_B keep only write bits 15:0, and their bits 31:16 read as zero.
- R8: The cfg_err pin, and STATUS bit4, are high while a half in edge-count mode has a load value less than or equal to its match value.
- R9: STATUS flags are sticky. Writing 1 to a CLEAR bit clears that flag. A clear that lands in the same cycle as a new event leaves the flag set.
- R10: With join set, half A counts over the full 32-bit width. A count of 0x00010000 decrements to 0x0000FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register word address |
| wdata | input | 2*HW | Write data |
| rdata | output | 2*HW | Read data for addr (combinational) |
| edge_in_a | input | 1 | Asynchronous event input of half A |
| edge_in_b | input | 1 | Asynchronous event input of half B |
| irq_match_a | output | 1 | Sticky match flag of half A |
| irq_match_b | output | 1 | Sticky match flag of half B |
| done_a | output | 1 | Sticky completion flag of half A |
| done_b | output | 1 | Sticky completion flag of half B |
| pwm_a | output | 1 | PWM output of half A |
| pwm_b | output | 1 | PWM output of half B |
| cfg_err | output | 1 | Edge-count configuration error |

## Verification
The self-disable checks assume that no write to CTL lands in the same cycle as a one-shot reaching zero or an edge count reaching its match value. The bench therefore writes CTL only at start, or well after the half has stopped. The edge-step property assumes the synchronized input gives at most one rising edge per cycle. The bench holds each event pulse high and low for several cycles, longer than the synchronizer depth. Join and mode are only changed while both halves are idle, so the properties never see a running count move between widths.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   typedef enum logic [1:0] {
      MODE_ONESHOT  = 2'd0,
      MODE_PERIODIC = 2'd1,
      MODE_EDGE     = 2'd2,
      MODE_PWM      = 2'd3
   } tmr_mode_e;

   localparam int A_CFG     = 0;
   localparam int A_CTL     = 1;
   localparam int A_LOAD_A  = 2;
   localparam int A_LOAD_B  = 3;
   localparam int A_MATCH_A = 4;
   localparam int A_MATCH_B = 5;
   localparam int A_VALUE_A = 6;
   localparam int A_VALUE_B = 7;
   localparam int A_STATUS  = 8;
   localparam int A_CLEAR   = 9;

   localparam int NUM_FLAGS = 4;

endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
   parameter int STAGES = 2,
   parameter bit RISING = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic tick
);

   if (STAGES < 2) begin : g_bad_stages
      $error("tmr_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES:0] sh_q;

   always_ff @(posedge clk) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-1:0], din};
   end

   if (RISING) begin : g_rise
      assign tick = sh_q[STAGES-1] & ~sh_q[STAGES];
   end else begin : g_fall
      assign tick = ~sh_q[STAGES-1] & sh_q[STAGES];
   end

endmodule

// File: rtl/tmr_sticky.sv
module tmr_sticky #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= (q & ~clr) | set;
   end

endmodule

// File: rtl/tmr_half.sv
module tmr_half
   import tmr_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  tmr_mode_e    mode,
   input  logic         en,
   input  logic         start,
   input  logic [W-1:0] load_v,
   input  logic [W-1:0] match_v,
   input  logic         tick,
   output logic [W-1:0] cnt,
   output logic         stop,
   output logic         match_ev,
   output logic         pwm
);

   if (W < 2) begin : g_bad_width
      $error("tmr_half: W must be at least 2");
   end

   logic at_zero;
   logic at_match;

   assign at_zero  = (cnt == '0);
   assign at_match = (cnt == match_v);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         pwm <= 1'b0;
      end else if (start) begin
         cnt <= load_v;
         pwm <= (mode == MODE_PWM);
      end else if (!en) begin
         pwm <= 1'b0;
      end else begin
         pwm <= 1'b0;
         case (mode)
            MODE_ONESHOT: begin
               if (!at_zero) cnt <= cnt - W'(1);
            end
            MODE_PERIODIC: begin
               cnt <= at_zero ? load_v : cnt - W'(1);
            end
            MODE_EDGE: begin
               if (tick && !at_match) cnt <= cnt - W'(1);
            end
            default: begin
               if (at_zero) begin
                  cnt <= load_v;
                  pwm <= 1'b1;
               end else begin
                  cnt <= cnt - W'(1);
                  pwm <= pwm & ~at_match;
               end
            end
         endcase
      end
   end

   assign match_ev = en && at_match &&
                     (mode == MODE_ONESHOT || mode == MODE_PERIODIC);
   assign stop     = en && ((mode == MODE_ONESHOT && at_zero) ||
                            (mode == MODE_EDGE && at_match));

endmodule

// File: rtl/mm_timer.sv
module mm_timer
   import tmr_pkg::*;
#(
   parameter int HW          = 16,
   parameter int AW          = 4,
   parameter int SYNC_STAGES = 2,
   localparam int DW         = 2 * HW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   input  logic          edge_in_a,
   input  logic          edge_in_b,
   output logic          irq_match_a,
   output logic          irq_match_b,
   output logic          done_a,
   output logic          done_b,
   output logic          pwm_a,
   output logic          pwm_b,
   output logic          cfg_err
);

   if (HW < 4 || HW > 32) begin : g_bad_hw
      $error("mm_timer: HW must lie in 4..32");
   end
   if (AW < 4) begin : g_bad_aw
      $error("mm_timer: AW must be at least 4 to hold the register map");
   end

   // configuration and control state
   logic              join_q;
   tmr_mode_e         mode_a_q, mode_b_q;
   logic [1:0]        en_q;
   logic [HW-1:0]     load_a_q, load_b_q, match_a_q, match_b_q;

   logic              cfg_wr, ctl_wr, la_wr, lb_wr, ma_wr, mb_wr, clr_wr;
   logic              start_a, start_b, en_b_eff;
   logic              stop_a, stop_b, mev_a, mev_b;
   logic [DW-1:0]     load_a_eff, match_a_eff, cnt_a;
   logic [HW-1:0]     cnt_b;
   logic [1:0]        tick;
   logic [1:0]        edge_vec;
   logic [NUM_FLAGS-1:0] flags, flag_set, flag_clr;

   assign cfg_wr = wr_en && addr == AW'(A_CFG);
   assign ctl_wr = wr_en && addr == AW'(A_CTL);
   assign la_wr  = wr_en && addr == AW'(A_LOAD_A);
   assign lb_wr  = wr_en && addr == AW'(A_LOAD_B) && !join_q;
   assign ma_wr  = wr_en && addr == AW'(A_MATCH_A);
   assign mb_wr  = wr_en && addr == AW'(A_MATCH_B) && !join_q;
   assign clr_wr = wr_en && addr == AW'(A_CLEAR);

   assign en_b_eff = en_q[1] & ~join_q;
   assign start_a  = ctl_wr && wdata[0] && !en_q[0];
   assign start_b  = ctl_wr && wdata[1] && !en_q[1] && !join_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         join_q    <= 1'b0;
         mode_a_q  <= MODE_ONESHOT;
         mode_b_q  <= MODE_ONESHOT;
         en_q      <= '0;
         load_a_q  <= '0;
         load_b_q  <= '0;
         match_a_q <= '1;
         match_b_q <= '1;
      end else begin
         if (cfg_wr) begin
            join_q   <= wdata[0];
            mode_a_q <= tmr_mode_e'(wdata[2:1]);
            mode_b_q <= tmr_mode_e'(wdata[4:3]);
         end
         if (ctl_wr) begin
            en_q <= wdata[1:0];
         end else begin
            if (stop_a) en_q[0] <= 1'b0;
            if (stop_b) en_q[1] <= 1'b0;
         end
         if (la_wr) begin
            load_a_q <= wdata[HW-1:0];
            if (join_q) load_b_q <= wdata[DW-1:HW];
         end
         if (lb_wr) load_b_q <= wdata[HW-1:0];
         if (ma_wr) begin
            match_a_q <= wdata[HW-1:0];
            if (join_q) match_b_q <= wdata[DW-1:HW];
         end
         if (mb_wr) match_b_q <= wdata[HW-1:0];
      end
   end

   // 32-bit view of half A
   assign load_a_eff  = join_q ? {load_b_q, load_a_q}  : {{HW{1'b0}}, load_a_q};
   assign match_a_eff = join_q ? {match_b_q, match_a_q} : {{HW{1'b0}}, match_a_q};

   // input synchronizers
   assign edge_vec = {edge_in_b, edge_in_a};
   for (genvar i = 0; i < 2; i++) begin : g_sync
      tmr_sync_edge #(.STAGES(SYNC_STAGES), .RISING(1'b1)) u_sync (
         .clk  (clk),
         .rst_n(rst_n),
         .din  (edge_vec[i]),
         .tick (tick[i])
      );
   end

   tmr_half #(.W(DW)) u_half_a (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (mode_a_q),
      .en      (en_q[0]),
      .start   (start_a),
      .load_v  (load_a_eff),
      .match_v (match_a_eff),
      .tick    (tick[0]),
      .cnt     (cnt_a),
      .stop    (stop_a),
      .match_ev(mev_a),
      .pwm     (pwm_a)
   );

   tmr_half #(.W(HW)) u_half_b (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (mode_b_q),
      .en      (en_b_eff),
      .start   (start_b),
      .load_v  (load_b_q),
      .match_v (match_b_q),
      .tick    (tick[1]),
      .cnt     (cnt_b),
      .stop    (stop_b),
      .match_ev(mev_b),
      .pwm     (pwm_b)
   );

   assign flag_set = {stop_b, stop_a, mev_b, mev_a};
   assign flag_clr = clr_wr ? wdata[NUM_FLAGS-1:0] : '0;

   tmr_sticky #(.N(NUM_FLAGS)) u_flags (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (flag_set),
      .clr  (flag_clr),
      .q    (flags)
   );

   assign irq_match_a = flags[0];
   assign irq_match_b = flags[1];
   assign done_a      = flags[2];
   assign done_b      = flags[3];

   assign cfg_err = (mode_a_q == MODE_EDGE && load_a_eff <= match_a_eff) ||
                    (!join_q && mode_b_q == MODE_EDGE && load_b_q <= match_b_q);

   always_comb begin
      rdata = '0;
      case (addr)
         AW'(A_CFG):     rdata = DW'({mode_b_q, mode_a_q, join_q});
         AW'(A_CTL):     rdata = DW'(en_q);
         AW'(A_LOAD_A):  rdata = load_a_eff;
         AW'(A_LOAD_B):  rdata = DW'(load_b_q);
         AW'(A_MATCH_A): rdata = match_a_eff;
         AW'(A_MATCH_B): rdata = DW'(match_b_q);
         AW'(A_VALUE_A): rdata = cnt_a;
         AW'(A_VALUE_B): rdata = DW'(cnt_b);
         AW'(A_STATUS):  rdata = DW'({cfg_err, flags});
         default:        rdata = '0;
      endcase
   end

endmodule

module mm_timer_chk
   import tmr_pkg::*;
#(
   parameter int HW = 16,
   parameter int AW = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            wr_en,
   input logic [AW-1:0]   addr,
   input logic [3:0]      wlow,
   input logic [HW-1:0]   rdata_hi,
   input logic            join_q,
   input logic [1:0]      mode_a,
   input logic [1:0]      mode_b,
   input logic [1:0]      en_q,
   input logic [2*HW-1:0] cnt_a,
   input logic [HW-1:0]   cnt_b,
   input logic [HW-1:0]   match_b_q,
   input logic [3:0]      flags,
   input logic            start_a,
   input logic            start_b,
   input logic            pwm_a
);

   logic       ctl_w;
   logic [3:0] keep;

   assign ctl_w = wr_en && addr == AW'(A_CTL);
   assign keep  = flags & ~((wr_en && addr == AW'(A_CLEAR)) ? wlow : 4'b0);

   // R9
   flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flags & $past(keep)) == $past(keep)));

   // R6
   match_b_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == AW'(A_MATCH_B) && join_q) |=> $stable(match_b_q));

   // R7
   upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == AW'(A_MATCH_B)) |-> (rdata_hi == '0));

   // R2
   oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[0] && mode_a == 2'(MODE_ONESHOT) && cnt_a == '0 && !ctl_w) |=> !en_q[0]);

   // R4
   edge_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[1] && !join_q && mode_b == 2'(MODE_EDGE) && cnt_b == match_b_q && !ctl_w)
      |=> (!en_q[1] && $stable(cnt_b)));

   // R4
   edge_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[1] && !join_q && mode_b == 2'(MODE_EDGE) && !start_b)
      |=> (cnt_b == $past(cnt_b) || cnt_b == $past(cnt_b) - HW'(1)));

   // R5
   pwm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q[0] && !start_a) |=> !pwm_a);

endmodule

bind mm_timer mm_timer_chk #(.HW(HW), .AW(AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .addr     (addr),
   .wlow     (wdata[3:0]),
   .rdata_hi (rdata[2*HW-1:HW]),
   .join_q   (join_q),
   .mode_a   (mode_a_q),
   .mode_b   (mode_b_q),
   .en_q     (en_q),
   .cnt_a    (cnt_a),
   .cnt_b    (cnt_b),
   .match_b_q(match_b_q),
   .flags    (flags),
   .start_a  (start_a),
   .start_b  (start_b),
   .pwm_a    (pwm_a)
);

// File: tb/mm_timer_tb.sv
module mm_timer_tb;

   localparam int A_CFG = 0, A_CTL = 1, A_LOAD_A = 2, A_LOAD_B = 3;
   localparam int A_MATCH_A = 4, A_MATCH_B = 5, A_VALUE_A = 6, A_VALUE_B = 7;
   localparam int A_STATUS = 8, A_CLEAR = 9;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        edge_in_a = 1'b0, edge_in_b = 1'b0;
   logic        irq_match_a, irq_match_b, done_a, done_b, pwm_a, pwm_b, cfg_err;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   typedef struct {
      string       tag;
      logic [31:0] exp;
   } sb_item_t;

   sb_item_t sb_q[$];
   event     rd_ev;

   // 125 MHz: 8 time-unit period
   always #4 clk = ~clk;

   mm_timer u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .edge_in_a(edge_in_a), .edge_in_b(edge_in_b),
      .irq_match_a(irq_match_a), .irq_match_b(irq_match_b),
      .done_a(done_a), .done_b(done_b), .pwm_a(pwm_a), .pwm_b(pwm_b),
      .cfg_err(cfg_err)
   );

   // monitor: pops the expected item for each read and compares
   initial begin
      sb_item_t it;
      forever begin
         @(rd_ev);
         it = sb_q.pop_front();
         checks++;
         if (rdata !== it.exp) begin
            errors++;
            $display("FAIL %s: read 0x%08h expected 0x%08h", it.tag, rdata, it.exp);
         end
      end
   end

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      addr  = a[3:0];
      wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, input logic [31:0] exp, input string tag);
      sb_item_t it;
      addr = a[3:0];
      #1;
      it.tag = tag;
      it.exp = exp;
      sb_q.push_back(it);
      ->rd_ev;
      #1;
   endtask

   task automatic chk_pin(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_b();
      @(negedge clk);
      edge_in_b = 1'b1;
      repeat (4) @(negedge clk);
      edge_in_b = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic pwm_high(input int n, output int hi, output int rises);
      logic prev;
      hi = 0;
      rises = 0;
      prev = pwm_a;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (pwm_a) hi++;
         if (pwm_a && !prev) rises++;
         prev = pwm_a;
      end
   endtask

   initial begin
      repeat (300000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int hi, rises;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      rd(A_MATCH_A, 32'h0000_FFFF, "R1 match A reset");
      rd(A_MATCH_B, 32'h0000_FFFF, "R1 match B reset");
      rd(A_CTL, 32'h0, "R1 ctl reset");
      rd(A_STATUS, 32'h0, "R1 status reset");
      chk_pin("R1 pins low", int'({irq_match_a, irq_match_b, done_a, done_b, pwm_a, pwm_b, cfg_err}), 0);

      // R2 one-shot: load 5, match 3
      wr(A_LOAD_A, 32'd5);
      wr(A_MATCH_A, 32'd3);
      wr(A_CFG, 32'h0);
      wr(A_CTL, 32'h1);
      rd(A_VALUE_A, 32'd5, "R2 count loaded");
      idle(2);
      rd(A_STATUS, 32'h0, "R2 no match yet");
      idle(1);
      rd(A_STATUS, 32'h1, "R2 match flag at equality");
      chk_pin("R2 irq pin", int'(irq_match_a), 1);
      idle(10);
      rd(A_VALUE_A, 32'd0, "R2 stopped at zero");
      rd(A_CTL, 32'h0, "R2 enable cleared");
      rd(A_STATUS, 32'h5, "R2 done flag");
      wr(A_CLEAR, 32'hF);
      rd(A_STATUS, 32'h0, "R9 clear by write-1");

      // R3 periodic + R9 simultaneous set/clear: load 3, match 3
      wr(A_LOAD_A, 32'd3);
      wr(A_CFG, 32'h2);
      wr(A_CTL, 32'h1);
      rd(A_VALUE_A, 32'd3, "R3 count loaded");
      idle(3);
      rd(A_VALUE_A, 32'd0, "R3 holds zero one cycle");
      wr(A_CLEAR, 32'h1);
      rd(A_VALUE_A, 32'd2, "R3 reloaded after zero");
      rd(A_STATUS, 32'h1, "R9 set wins over clear");
      wr(A_CTL, 32'h0);
      wr(A_CLEAR, 32'hF);
      rd(A_STATUS, 32'h0, "R9 cleared while idle");

      // R5 PWM: load 9, match 3
      wr(A_LOAD_A, 32'd9);
      wr(A_CFG, 32'h6);
      wr(A_CTL, 32'h1);
      idle(12);
      pwm_high(10, hi, rises);
      chk_pin("R5 high cycles per period", hi, 7);
      pwm_high(30, hi, rises);
      chk_pin("R5 period length", rises, 3);
      wr(A_MATCH_A, 32'd0);
      idle(12);
      pwm_high(10, hi, rises);
      chk_pin("R5 match zero stays high", hi, 10);
      wr(A_CTL, 32'h0);
      idle(2);
      chk_pin("R5 low when disabled", int'(pwm_a), 0);

      // R8 config error, R4 edge count on half B
      wr(A_CFG, 32'h10);
      wr(A_LOAD_B, 32'd2);
      wr(A_MATCH_B, 32'd2);
      chk_pin("R8 error when load equals match", int'(cfg_err), 1);
      rd(A_STATUS, 32'h10, "R8 status bit");
      wr(A_LOAD_B, 32'd6);
      chk_pin("R8 clear when load above match", int'(cfg_err), 0);
      wr(A_CTL, 32'h2);
      rd(A_VALUE_B, 32'd6, "R4 count loaded");
      pulse_b();
      pulse_b();
      pulse_b();
      rd(A_VALUE_B, 32'd3, "R4 three edges counted");
      rd(A_CTL, 32'h2, "R4 still enabled");
      pulse_b();
      rd(A_VALUE_B, 32'd2, "R4 reached match");
      rd(A_CTL, 32'h0, "R4 self disabled");
      rd(A_STATUS, 32'h8, "R4 done flag");
      pulse_b();
      rd(A_VALUE_B, 32'd2, "R4 edge after done ignored");
      wr(A_CLEAR, 32'hF);

      // R6 / R10 joined mode
      wr(A_CFG, 32'h1);
      wr(A_LOAD_A, 32'h0001_0002);
      rd(A_LOAD_A, 32'h0001_0002, "R10 joined load");
      wr(A_MATCH_A, 32'h0001_0000);
      rd(A_MATCH_A, 32'h0001_0000, "R6 joined match read");
      rd(A_MATCH_B, 32'h0000_0001, "R6 match B holds upper half");
      wr(A_MATCH_B, 32'h0000_1234);
      rd(A_MATCH_B, 32'h0000_0001, "R6 match B write ignored");
      wr(A_CTL, 32'h1);
      rd(A_VALUE_A, 32'h0001_0002, "R10 32-bit count loaded");
      idle(3);
      rd(A_VALUE_A, 32'h0000_FFFF, "R10 borrow across halves");
      rd(A_STATUS, 32'h1, "R6 32-bit match flag");
      wr(A_CTL, 32'h0);
      wr(A_CLEAR, 32'hF);

      // R7 16-bit modes
      wr(A_CFG, 32'h0);
      rd(A_MATCH_A, 32'h0000_0000, "R7 unjoined match A width");
      wr(A_MATCH_A, 32'hABCD_1234);
      rd(A_MATCH_A, 32'h0000_1234, "R7 match A upper bits dropped");
      wr(A_MATCH_B, 32'hFFFF_5678);
      rd(A_MATCH_B, 32'h0000_5678, "R7 match B upper bits dropped");

      #3;
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule